// File: doc/BRIEF.md
# Auto-Reload Timer with Split and Capture Modes

This block is a 16-bit up-counter made of two 8-bit byte lanes. On overflow it reloads itself from a 16-bit reload value. A mode bit changes how the lanes work. In one setting they form a single 16-bit counter. In the other they run as two separate 8-bit counters, each reloading from its own reload byte. A capture bit adds a snapshot feature: each synchronized rising edge of an external comparator signal copies the live count into a capture register.

The count advances on ticks from one of three sources:

- the system clock;
- the system clock divided by twelve;
- a slow external clock divided by eight. This clock is first resynchronized into the system clock domain.

Overflow events set sticky flags in the control register. The flags, the interrupt enable bit for low-byte overflows and the interrupt enable input together drive a registered interrupt request. Software loads the control, count and reload bytes through a single-cycle write port. It reads the control byte, including the flags, back on an output.

Top module: `autoreload_timer`

## Requirements
- R1: A synchronous reset clears the control byte, count, reload value, capture value and interrupt request to zero.
- R2: A write with wr_sel 0 loads the control byte, 1 the count low byte, 2 the count high byte, 3 the reload low byte and 4 the reload high byte. A write to either count byte suppresses counting in that cycle. A control write overrides any flag set in the same cycle.
- R3: Control bits [1:0] choose the tick source:
  - 00 gives a tick every cycle.
  - 01 gives a tick every twelfth cycle, from a free-running prescaler.
  - 10 gives a tick on every eighth rising edge of ext_clk, after a two-flop synchronizer.
  - 11 gives no ticks.
- R4: While control bit 2 (run) is 0, the count holds its value.
- R5: With control bit 3 at 0, each tick increments the 16-bit count. A tick at 0xFFFF loads the 16-bit reload value and sets the high flag, control bit 7.
- R6: In 16-bit mode, a tick that wraps the low byte from 0xFF sets the low flag, control bit 6, only when control bit 5 is 1.
- R7: With control bit 3 at 1, each byte counts on every tick. A byte at 0xFF loads its own reload byte and sets its own flag: bit 6 for the low byte, bit 7 for the high byte.
- R8: Both flags stay set until a control write changes them.
- R9: irq_o equals irq_en AND (bit 7 OR (bit 5 AND bit 6)), evaluated on the previous cycle's values.
- R10: With control bit 4 at 1, each rising edge of comp_in produces exactly one capture of the count. The edge passes through a two-flop synchronizer, so the capture happens on the third clock edge after comp_in rises. The capture value is unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Target register of the write |
| wr_data | input | 8 | Write data byte |
| irq_en | input | 1 | Timer interrupt enable |
| ext_clk | input | 1 | Slow external clock, asynchronous |
| comp_in | input | 1 | Comparator output, asynchronous |
| ctrl_o | output | 8 | Control byte including flags |
| count_o | output | 16 | Current count |
| capture_o | output | 16 | Last captured count |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check the following on every cycle:

- the spacing of divide-by-twelve ticks;
- single-cycle edge pulses;
- holding while stopped;
- reloading at full-count wrap;
- flag stickiness;
- gating of the interrupt by irq_en;
- capture stability between edges.

Only the bench's scenarios show the exact tick counts for each clock source, the split-lane reload values and the synchronizer latency of a capture. A behavioural model reproduces these sequences cycle by cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int SEL_W  = 3;

  localparam int CB_FLAG_HI = 7;
  localparam int CB_FLAG_LO = 6;
  localparam int CB_LO_IRQ  = 5;
  localparam int CB_CAPT    = 4;
  localparam int CB_SPLIT   = 3;
  localparam int CB_RUN     = 2;

  typedef enum logic [1:0] {
    SRC_SYS   = 2'b00,
    SRC_DIV   = 2'b01,
    SRC_EXT   = 2'b10,
    SRC_NONE  = 2'b11
  } tick_src_e;

  localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CNTL  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CNTH  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_RLDL  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_RLDH  = 3'd4;
endpackage

// File: rtl/timer_edge_sync.sv
module timer_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R10 / R3: a synchronized edge yields a one-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
  import timer_pkg::*;
#(
  parameter int SYS_DIV = 12,
  parameter int EXT_DIV = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  tick_src_e src,
  input  logic      ext_clk,
  output logic      tick_o
);
  localparam int PW = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam int EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(SYS_DIV - 1);
  localparam logic [EW-1:0] E_LAST = EW'(EXT_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [EW-1:0] ext_cnt_q;
  logic          ext_rise;

  timer_edge_sync #(.STAGES(2)) u_ext_sync (
    .clk(clk), .rst(rst), .async_in(ext_clk), .rise_o(ext_rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q     <= '0;
      ext_cnt_q <= '0;
    end else begin
      pre_q <= (pre_q == P_LAST) ? '0 : pre_q + 1'b1;
      if (ext_rise)
        ext_cnt_q <= (ext_cnt_q == E_LAST) ? '0 : ext_cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (src)
      SRC_SYS:  tick_o = 1'b1;
      SRC_DIV:  tick_o = (pre_q == P_LAST);
      SRC_EXT:  tick_o = ext_rise && (ext_cnt_q == E_LAST);
      default:  tick_o = 1'b0;
    endcase
  end

  // R3: divided system ticks never come back to back
  a_r3_div_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick_o && src == SRC_DIV) |=> !(tick_o && src == SRC_DIV));
  // R3: the idle source never ticks
  a_r3_none_quiet: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_NONE) |-> !tick_o);
endmodule

// File: rtl/timer_byte_lane.sv
module timer_byte_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         step,
  input  logic         reload,
  input  logic [W-1:0] rl_val,
  output logic [W-1:0] val_o,
  output logic         at_top_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst)
      val_q <= '0;
    else if (wr)
      val_q <= wr_data;
    else if (step)
      val_q <= reload ? rl_val : val_q + 1'b1;
  end

  assign val_o    = val_q;
  assign at_top_o = &val_q;

  // R4: a lane with neither step nor write keeps its value
  a_r4_lane_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !wr) |=> $stable(val_q));
endmodule

// File: rtl/timer_count_core.sv
module timer_count_core
  import timer_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  input  logic           split,
  input  logic           wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]   wr_data,
  output logic [2*W-1:0] count_o,
  output logic           wrap_lo_o,
  output logic           wrap_hi_o
);
  localparam int LANES = 2;

  logic [W-1:0] rl_q   [LANES];
  logic [W-1:0] val    [LANES];
  logic         top    [LANES];
  logic         step   [LANES];
  logic         reload [LANES];
  logic         wr_l   [LANES];
  logic         wrap   [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      rl_q[0] <= '0;
      rl_q[1] <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_RLDL) rl_q[0] <= wr_data;
      if (wr_sel == SEL_RLDH) rl_q[1] <= wr_data;
    end
  end

  always_comb begin
    step[0]   = adv;
    wrap[0]   = step[0] & top[0];
    step[1]   = split ? adv : wrap[0];
    wrap[1]   = step[1] & top[1];
    reload[0] = split ? wrap[0] : wrap[1];
    reload[1] = wrap[1];
    wr_l[0]   = wr_en && (wr_sel == SEL_CNTL);
    wr_l[1]   = wr_en && (wr_sel == SEL_CNTH);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    timer_byte_lane #(.W(W)) u_lane (
      .clk(clk), .rst(rst),
      .wr(wr_l[g]), .wr_data(wr_data),
      .step(step[g]), .reload(reload[g]), .rl_val(rl_q[g]),
      .val_o(val[g]), .at_top_o(top[g])
    );
  end

  assign count_o   = {val[1], val[0]};
  assign wrap_lo_o = wrap[0];
  assign wrap_hi_o = wrap[1];

  // R5: full-count wrap in joined mode loads the reload pair
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (adv && !split && count_o == '1 && !wr_en) |=> count_o == $past({rl_q[1], rl_q[0]}));
  // R4: no advance and no count write keeps the count
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !(wr_en && (wr_sel == SEL_CNTL || wr_sel == SEL_CNTH))) |=> $stable(count_o));
endmodule

// File: rtl/autoreload_timer.sv
module autoreload_timer
  import timer_pkg::*;
#(
  parameter int SYS_DIV = 12,
  parameter int EXT_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              irq_en,
  input  logic              ext_clk,
  input  logic              comp_in,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  capture_o,
  output logic              irq_o
);
  logic [BYTE_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cap_q;
  logic              irq_q;
  logic              tick, adv, cnt_wr, ctrl_wr;
  logic              wrap_lo, wrap_hi, comp_rise;
  logic [CNT_W-1:0]  count;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign cnt_wr  = wr_en && (wr_sel == SEL_CNTL || wr_sel == SEL_CNTH);
  assign adv     = tick && ctrl_q[CB_RUN] && !cnt_wr;

  timer_tick_gen #(.SYS_DIV(SYS_DIV), .EXT_DIV(EXT_DIV)) u_tick (
    .clk(clk), .rst(rst), .src(tick_src_e'(ctrl_q[1:0])),
    .ext_clk(ext_clk), .tick_o(tick)
  );

  timer_count_core #(.W(BYTE_W)) u_core (
    .clk(clk), .rst(rst), .adv(adv), .split(ctrl_q[CB_SPLIT]),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count_o(count), .wrap_lo_o(wrap_lo), .wrap_hi_o(wrap_hi)
  );

  timer_edge_sync #(.STAGES(2)) u_comp_sync (
    .clk(clk), .rst(rst), .async_in(comp_in), .rise_o(comp_rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cap_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= irq_en && (ctrl_q[CB_FLAG_HI] || (ctrl_q[CB_LO_IRQ] && ctrl_q[CB_FLAG_LO]));
      if (ctrl_wr) begin
        ctrl_q <= wr_data;
      end else begin
        if (wrap_hi) ctrl_q[CB_FLAG_HI] <= 1'b1;
        if (wrap_lo && (ctrl_q[CB_SPLIT] || ctrl_q[CB_LO_IRQ]))
          ctrl_q[CB_FLAG_LO] <= 1'b1;
      end
      if (comp_rise && ctrl_q[CB_CAPT])
        cap_q <= count;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign count_o   = count;
  assign capture_o = cap_q;
  assign irq_o     = irq_q;

  // R8: flags survive until a control write
  a_r8_hi_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_FLAG_HI] && !ctrl_wr) |=> ctrl_q[CB_FLAG_HI]);
  a_r8_lo_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_FLAG_LO] && !ctrl_wr) |=> ctrl_q[CB_FLAG_LO]);
  // R9: no request while the enable is low
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq_o);
  // R10: capture value changes only on a synchronized edge
  a_r10_cap_stable: assert property (@(posedge clk) disable iff (rst)
    !(comp_rise && ctrl_q[CB_CAPT]) |=> $stable(cap_q));
endmodule

// File: tb/autoreload_timer_tb.sv
module autoreload_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        irq_en = 1'b0;
  logic        ext_clk = 1'b0;
  logic        comp_in = 1'b0;
  logic [7:0]  ctrl_o;
  logic [15:0] count_o, capture_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  autoreload_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_en(irq_en), .ext_clk(ext_clk), .comp_in(comp_in),
    .ctrl_o(ctrl_o), .count_o(count_o), .capture_o(capture_o), .irq_o(irq_o)
  );

  // behavioural reference state
  int m_ctrl, m_lo, m_hi, m_rl_lo, m_rl_hi, m_cap, m_irq;
  int m_pre, m_ecnt;
  bit m_e1, m_e2, m_e3, m_c1, m_c2, m_c3;

  always @(posedge clk) begin
    bit tk, e_edge, c_edge, adv, w0, w1, split;
    int v, lo_n, hi_n, ctrl_n, cap_n, irq_n;
    if (rst) begin
      m_ctrl = 0; m_lo = 0; m_hi = 0; m_rl_lo = 0; m_rl_hi = 0; m_cap = 0; m_irq = 0;
      m_pre = 0; m_ecnt = 0; m_e1 = 0; m_e2 = 0; m_e3 = 0; m_c1 = 0; m_c2 = 0; m_c3 = 0;
    end else begin
      e_edge = m_e2 && !m_e3;
      c_edge = m_c2 && !m_c3;
      case (m_ctrl & 3)
        0: tk = 1;
        1: tk = (m_pre == 11);
        2: tk = e_edge && (m_ecnt == 7);
        default: tk = 0;
      endcase
      split = m_ctrl[3];
      adv = tk && m_ctrl[2] && !(wr_en && (wr_sel == 1 || wr_sel == 2));
      lo_n = m_lo; hi_n = m_hi; w0 = 0; w1 = 0;
      if (adv) begin
        if (split) begin
          if (m_lo == 255) begin lo_n = m_rl_lo; w0 = 1; end else lo_n = m_lo + 1;
          if (m_hi == 255) begin hi_n = m_rl_hi; w1 = 1; end else hi_n = m_hi + 1;
        end else begin
          v = m_hi * 256 + m_lo;
          if (m_lo == 255) w0 = 1;
          if (v == 65535) begin v = m_rl_hi * 256 + m_rl_lo; w1 = 1; end
          else v = v + 1;
          lo_n = v % 256; hi_n = v / 256;
        end
      end
      ctrl_n = m_ctrl;
      if (w1) ctrl_n = ctrl_n | 128;
      if (w0 && (split || m_ctrl[5])) ctrl_n = ctrl_n | 64;
      irq_n = (irq_en && (m_ctrl[7] || (m_ctrl[5] && m_ctrl[6]))) ? 1 : 0;
      cap_n = (c_edge && m_ctrl[4]) ? m_hi * 256 + m_lo : m_cap;
      if (wr_en) begin
        case (wr_sel)
          0: ctrl_n = wr_data;
          1: lo_n = wr_data;
          2: hi_n = wr_data;
          3: m_rl_lo = wr_data;
          4: m_rl_hi = wr_data;
          default: ;
        endcase
      end
      m_ctrl = ctrl_n; m_lo = lo_n; m_hi = hi_n; m_cap = cap_n; m_irq = irq_n;
      m_pre = (m_pre == 11) ? 0 : m_pre + 1;
      if (e_edge) m_ecnt = (m_ecnt + 1) % 8;
      m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk;
      m_c3 = m_c2; m_c2 = m_c1; m_c1 = comp_in;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(count_o == 16'(m_hi * 256 + m_lo), "R5 count", count_o, m_hi * 256 + m_lo);
      check(ctrl_o == 8'(m_ctrl), "R8 ctrl", ctrl_o, m_ctrl);
      check(irq_o == m_irq[0], "R9 irq", irq_o, m_irq);
      check(capture_o == 16'(m_cap), "R10 capture", capture_o, m_cap);
    end
  end

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        done = 1;
      end
    end
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(ctrl_o == 0 && count_o == 0 && capture_o == 0 && !irq_o, "R1 reset", count_o, 0);

    // R2 / R5: 16-bit reload at full count
    irq_en = 1'b1;
    wr(1, 8'hFA); wr(2, 8'hFF); wr(3, 8'h34); wr(4, 8'h12);
    check(count_o == 16'hFFFA, "R2 count load", count_o, 16'hFFFA);
    wr(0, 8'h04);
    idle(6);
    check(count_o == 16'h1234, "R5 reload", count_o, 16'h1234);
    check(ctrl_o[7] == 1'b1, "R5 high flag", ctrl_o, 8'h84);
    idle(1);
    check(irq_o == 1'b1, "R9 irq high", irq_o, 1);
    idle(20);
    check(ctrl_o[7] == 1'b1, "R8 flag sticky", ctrl_o, 8'h84);

    // R8: clear by control write
    wr(0, 8'h00);
    idle(2);
    check(ctrl_o == 0 && !irq_o, "R8 flag cleared", ctrl_o, 0);

    // R6: low wrap without and with low enable
    wr(1, 8'hFD); wr(2, 8'h00);
    wr(0, 8'h04);
    idle(5);
    check(ctrl_o[6] == 1'b0, "R6 low flag off", ctrl_o, 8'h04);
    wr(0, 8'h00);
    wr(1, 8'hFD);
    wr(0, 8'h24);
    idle(5);
    check(ctrl_o[6] == 1'b1, "R6 low flag on", ctrl_o, 8'h64);
    idle(1);
    check(irq_o == 1'b1, "R9 low irq", irq_o, 1);

    // R4: stopped timer holds
    wr(0, 8'h00);
    snap = count_o;
    idle(15);
    check(count_o == 16'(snap), "R4 hold", count_o, snap);

    // R2: count write beats a tick
    wr(0, 8'h04);
    wr(1, 8'h10);
    check(count_o[7:0] == 8'h10, "R2 write priority", count_o[7:0], 8'h10);

    // R3: divide by twelve
    wr(0, 8'h00);
    wr(1, 8'h00); wr(2, 8'h00);
    wr(0, 8'h05);
    idle(120);
    check(count_o >= 9 && count_o <= 11, "R3 div12 rate", count_o, 10);

    // R3: idle source
    wr(0, 8'h07);
    snap = count_o;
    idle(30);
    check(count_o == 16'(snap), "R3 no source", count_o, snap);

    // R7: split mode
    wr(0, 8'h00);
    wr(3, 8'hF0); wr(4, 8'h80);
    wr(1, 8'hFE); wr(2, 8'hFC);
    wr(0, 8'h0C);
    idle(3);
    check(count_o == 16'hFFF1, "R7 split lanes", count_o, 16'hFFF1);
    check(ctrl_o[6] == 1'b1 && ctrl_o[7] == 1'b0, "R7 low flag only", ctrl_o, 8'h4C);
    idle(1);
    check(count_o == 16'h80F2 && ctrl_o[7], "R7 high reload", count_o, 16'h80F2);

    // R3: synchronized external clock
    wr(0, 8'h00);
    wr(1, 8'h00); wr(2, 8'h00);
    wr(0, 8'h06);
    for (int i = 0; i < 80; i++) begin
      ext_clk = ~ext_clk;
      idle(2);
    end
    check(count_o == 16'(m_hi * 256 + m_lo) && count_o >= 4, "R3 ext ticks", count_o, 5);

    // R10: capture
    wr(0, 8'h14);
    for (int i = 0; i < 4; i++) begin
      comp_in = 1'b1; idle(5);
      comp_in = 1'b0; idle(7);
    end
    check(capture_o != 0, "R10 capture taken", capture_o, m_cap);
    snap = capture_o;
    idle(10);
    check(capture_o == 16'(snap), "R10 capture stable", capture_o, snap);

    done = 1;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (done);
    #1;
  end
endmodule